// File: doc/BRIEF.md
# Interrupt Input Buffer

This block conditions one interrupt request line for a real-time interrupt manager. The raw line is brought into the clock domain by a synchronizer. It is then qualified by a per-line sensitivity setting. A two-bit level code and a two-bit edge code each have an off setting, so a line can react to a level, an edge, both, or neither.

Qualified events are counted in a saturating pending counter rather than kept as a single flag. The block shows a ready flag and the pending count. It also holds a priority value that can be rewritten at run time and that an external arbiter reads.

When the arbiter grants the line through the forward enable, the block raises a registered forward output. Each acknowledge taken while that output is high consumes one pending request.

Top module: `irq_input_buffer`

## Requirements
- R1: The raw line passes through two synchronizing flops. A change driven between two rising edges is first counted at the third rising edge that follows it.
- R2: Level code `lvl_cfg`: 00 qualifies a synchronized low line, 01 qualifies a synchronized high line, and 10 and 11 turn level detection off.
- R3: Edge code `edg_cfg`: 01 qualifies rising edges, 10 qualifies falling edges, 11 qualifies both, and 00 turns edge detection off. A level event and an edge event in the same cycle add one pending request.
- R4: A level event adds at most one pending request until an acknowledge is accepted. A level held active does not add a request on every clock.
- R5: `ready` is high exactly when `pend_cnt` is nonzero.
- R6: `pend_cnt` is 4 bits wide and stays at 15 on a further event instead of wrapping.
- R7: An acknowledge is accepted when `ack` is high in a cycle where `irq_fwd` and `ready` are high. An accepted acknowledge lowers `pend_cnt` by one at the next edge. An acknowledge while `irq_fwd` is low has no effect on the count.
- R8: An event and an accepted acknowledge in the same cycle leave `pend_cnt` unchanged.
- R9: When `prio_load` is high at a rising edge, `prio` takes `prio_new`. Otherwise `prio` holds its value.
- R10: `irq_fwd` is registered. It is high one edge after a cycle in which `ready` and `fwd_en` are both high, and low after any other cycle.
- R11: Driving `rst_n` low clears the count, the priority, the forward output and the synchronizer at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_raw | input | 1 | Unsynchronized interrupt request line |
| lvl_cfg | input | 2 | Level sensitivity code |
| edg_cfg | input | 2 | Edge sensitivity code |
| prio_load | input | 1 | Priority load strobe |
| prio_new | input | 4 | Priority value to load |
| fwd_en | input | 1 | Grant from the external selector |
| ack | input | 1 | Service acknowledge |
| ready | output | 1 | At least one request pending |
| pend_cnt | output | 4 | Number of pending requests |
| prio | output | 4 | Stored priority |
| irq_fwd | output | 1 | Registered forwarded request |

## Verification
The delays to results are fixed. A count rises at the third rising edge after a line change. An acknowledge or event changes the count at the next edge. `ready` follows the count in the same cycle. `irq_fwd` trails `ready`/`fwd_en` by one edge, and `prio` changes one edge after the load strobe.

Inputs are driven on the falling clock edge, and the bench advances an exact number of edges before it samples, also on a falling edge. The latency case checks that the count is still zero after two edges and becomes one after the third. The coincident event and acknowledge case places `ack` in the exact cycle the synchronized edge is seen.

// File: rtl/irq_buf_pkg.sv
// Package: shared sensitivity encodings for the interrupt input buffer.
// Assumes: codes arrive as plain two-bit fields and are cast here.
package irq_buf_pkg;

    typedef enum logic [1:0] {
        LVL_LOW   = 2'b00,
        LVL_HIGH  = 2'b01,
        LVL_OFF_A = 2'b10,
        LVL_OFF_B = 2'b11
    } lvl_mode_e;

    typedef enum logic [1:0] {
        EDG_NONE = 2'b00,
        EDG_RISE = 2'b01,
        EDG_FALL = 2'b10,
        EDG_ANY  = 2'b11
    } edg_mode_e;

endpackage

// File: rtl/irq_line_sync.sv
// Module: multi-flop synchronizer plus a one-cycle delayed copy for edge detection.
// Assumes: STAGES >= 2; the raw line is asynchronous to clk.
module irq_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_raw,
    output logic line_s,
    output logic line_d
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First flop samples the asynchronous line.
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= line_raw;
                end
            end else begin : g_next
                // Later flops resolve metastability.
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    // Previous synchronized value for edge comparison.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) line_d <= 1'b0;
        else        line_d <= chain_q[LAST];
    end

    assign line_s = chain_q[LAST];

    p_delay_copy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> line_d == $past(line_s));

endmodule

// File: rtl/irq_event_detect.sv
// Module: turns the synchronized line into one-cycle event pulses per the level
// and edge codes; level events are limited to one per accepted acknowledge.
// Assumes: rearm is a single-cycle pulse for each accepted acknowledge.
module irq_event_detect
    import irq_buf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] lvl_cfg,
    input  logic [1:0] edg_cfg,
    input  logic       line_s,
    input  logic       line_d,
    input  logic       rearm,
    output logic       evt
);
    lvl_mode_e lvl_mode;
    edg_mode_e edg_mode;
    logic      lvl_hit;
    logic      edg_hit;
    logic      lvl_evt;
    logic      armed_q;
    logic      rise;
    logic      fall;

    assign lvl_mode = lvl_mode_e'(lvl_cfg);
    assign edg_mode = edg_mode_e'(edg_cfg);
    assign rise     = line_s & ~line_d;
    assign fall     = ~line_s & line_d;

    // Level qualification.
    always_comb begin
        case (lvl_mode)
            LVL_LOW:  lvl_hit = ~line_s;
            LVL_HIGH: lvl_hit = line_s;
            default:  lvl_hit = 1'b0;
        endcase
    end

    // Edge qualification.
    always_comb begin
        case (edg_mode)
            EDG_RISE: edg_hit = rise;
            EDG_FALL: edg_hit = fall;
            EDG_ANY:  edg_hit = rise | fall;
            default:  edg_hit = 1'b0;
        endcase
    end

    assign lvl_evt = lvl_hit & armed_q;
    assign evt     = lvl_evt | edg_hit;

    // Arm flag: a level event disarms, an accepted acknowledge rearms.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       armed_q <= 1'b1;
        else if (lvl_evt) armed_q <= 1'b0;
        else if (rearm)   armed_q <= 1'b1;
    end

    p_one_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_evt |=> !lvl_evt);

    p_off_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (edg_mode == EDG_NONE && lvl_cfg[1]) |-> !evt);

endmodule

// File: rtl/irq_pend_counter.sv
// Module: saturating up/down pending-request counter.
// Assumes: inc and dec are single-cycle qualified pulses; dec only when count > 0.
module irq_pend_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

    // Count update: coincident inc and dec cancel, top value saturates.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (inc && !dec) begin
            if (count != CNT_MAX) count <= count + ONE;
        end else if (dec && !inc) begin
            count <= count - ONE;
        end
    end

    p_no_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CNT_MAX && inc && !dec) |=> count == CNT_MAX);

    p_step_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !inc) |=> count == $past(count) - ONE);

    p_cancel_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && inc) |=> $stable(count));

    p_dec_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> count != '0);

endmodule

// File: rtl/irq_prio_reg.sv
// Module: run-time loadable priority register.
// Assumes: load is sampled on every rising edge.
module irq_prio_reg #(
    parameter int PRIO_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [PRIO_W-1:0] new_val,
    output logic [PRIO_W-1:0] value
);
    // Priority storage.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    value <= '0;
        else if (load) value <= new_val;
    end

    p_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> value == $past(new_val));

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(value));

endmodule

// File: rtl/irq_input_buffer.sv
// Module: top of one interrupt input buffer: synchronizer, event detection,
// pending counter, priority register and registered forward output.
// Assumes: arbitration between lines is done outside; fwd_en is the grant.
module irq_input_buffer #(
    parameter int CNT_W       = 4,
    parameter int PRIO_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_raw,
    input  logic [1:0]        lvl_cfg,
    input  logic [1:0]        edg_cfg,
    input  logic              prio_load,
    input  logic [PRIO_W-1:0] prio_new,
    input  logic              fwd_en,
    input  logic              ack,
    output logic              ready,
    output logic [CNT_W-1:0]  pend_cnt,
    output logic [PRIO_W-1:0] prio,
    output logic              irq_fwd
);
    logic line_s;
    logic line_d;
    logic evt;
    logic ack_ok;

    irq_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_raw (irq_raw),
        .line_s   (line_s),
        .line_d   (line_d)
    );

    irq_event_detect u_detect (
        .clk     (clk),
        .rst_n   (rst_n),
        .lvl_cfg (lvl_cfg),
        .edg_cfg (edg_cfg),
        .line_s  (line_s),
        .line_d  (line_d),
        .rearm   (ack_ok),
        .evt     (evt)
    );

    irq_pend_counter #(.CNT_W(CNT_W)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (evt),
        .dec   (ack_ok),
        .count (pend_cnt)
    );

    irq_prio_reg #(.PRIO_W(PRIO_W)) u_prio (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (prio_load),
        .new_val (prio_new),
        .value   (prio)
    );

    assign ready  = (pend_cnt != '0);
    assign ack_ok = ack & irq_fwd & ready;

    // Registered forward request.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_fwd <= 1'b0;
        else        irq_fwd <= ready & fwd_en;
    end

    p_fwd_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && fwd_en) |=> irq_fwd);

    p_fwd_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(ready && fwd_en) |=> !irq_fwd);

    p_ack_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !irq_fwd && !evt) |=> $stable(pend_cnt));

endmodule

// File: tb/irq_input_buffer_tb.sv
// Bench: table-driven sensitivity checks, then directed tests.
module irq_input_buffer_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       irq_raw = 1'b0;
    logic [1:0] lvl_cfg = 2'b10;
    logic [1:0] edg_cfg = 2'b00;
    logic       prio_load = 1'b0;
    logic [3:0] prio_new = 4'h0;
    logic       fwd_en = 1'b0;
    logic       ack = 1'b0;
    logic       ready;
    logic [3:0] pend_cnt;
    logic [3:0] prio;
    logic       irq_fwd;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    irq_input_buffer dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_raw   (irq_raw),
        .lvl_cfg   (lvl_cfg),
        .edg_cfg   (edg_cfg),
        .prio_load (prio_load),
        .prio_new  (prio_new),
        .fwd_en    (fwd_en),
        .ack       (ack),
        .ready     (ready),
        .pend_cnt  (pend_cnt),
        .prio      (prio),
        .irq_fwd   (irq_fwd)
    );

    // Row: {level code, edge code, start level, end level, expected count}
    localparam logic [7:0] VEC [0:11] = '{
        8'b10_00_0_1_00, 8'b11_00_1_0_00, 8'b01_00_0_1_01, 8'b00_00_1_1_01,
        8'b01_00_0_0_00, 8'b10_01_0_1_01, 8'b10_01_1_0_01, 8'b10_10_1_0_01,
        8'b10_10_0_1_00, 8'b10_11_1_0_10, 8'b10_00_1_0_00, 8'b01_11_1_0_10
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic restart(input logic [1:0] l, input logic [1:0] e, input logic r);
        @(negedge clk);
        rst_n   = 1'b0;
        lvl_cfg = l;
        edg_cfg = e;
        irq_raw = r;
        ack     = 1'b0;
        tick(2);
        rst_n = 1'b1;
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual 0 expected 1 (run finished)");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // Reset state, with a load strobe held during reset (R11)
        prio_load = 1'b1;
        prio_new  = 4'h5;
        fwd_en    = 1'b1;
        tick(3);
        chk("R11 count", pend_cnt, 0);
        chk("R11 ready", ready, 0);
        chk("R11 fwd", irq_fwd, 0);
        chk("R11 prio", prio, 0);
        prio_load = 1'b0;
        fwd_en    = 1'b0;

        // Table of sensitivity cases (R2/R3)
        for (int i = 0; i < 12; i++) begin
            restart(VEC[i][7:6], VEC[i][5:4], VEC[i][3]);
            tick(6);
            irq_raw = VEC[i][2];
            tick(6);
            chk(VEC[i][7] ? "R3 table" : "R2/R3 table", pend_cnt, int'(VEC[i][1:0]));
            chk("R5 table", ready, int'(VEC[i][1:0] != 2'b00));
        end

        // R1 latency: rising edge mode
        restart(2'b10, 2'b01, 1'b0);
        tick(5);
        irq_raw = 1'b1;
        tick(2);
        chk("R1 two edges", pend_cnt, 0);
        tick(1);
        chk("R1 third edge", pend_cnt, 1);

        // R6 saturation
        restart(2'b10, 2'b01, 1'b0);
        for (int k = 0; k < 20; k++) begin
            irq_raw = 1'b1; tick(3);
            irq_raw = 1'b0; tick(3);
        end
        tick(3);
        chk("R6 saturate", pend_cnt, 15);
        chk("R5 ready", ready, 1);
        chk("R10 no grant", irq_fwd, 0);

        // R7 acknowledge without forward is ignored
        ack = 1'b1; tick(1); ack = 1'b0; tick(1);
        chk("R7 ignored", pend_cnt, 15);
        fwd_en = 1'b1;
        tick(1);
        chk("R10 fwd after one edge", irq_fwd, 1);
        ack = 1'b1; tick(1); ack = 1'b0;
        chk("R7 one ack", pend_cnt, 14);
        ack = 1'b1; tick(3); ack = 1'b0;
        chk("R7 three acks", pend_cnt, 11);

        // R8 event coincides with accepted acknowledge
        irq_raw = 1'b1;
        tick(2);
        ack = 1'b1; tick(1); ack = 1'b0;
        chk("R8 same cycle", pend_cnt, 11);
        tick(1);
        chk("R8 after", pend_cnt, 11);

        // R11 asynchronous clear mid-cycle
        rst_n = 1'b0;
        #1;
        chk("R11 async count", pend_cnt, 0);
        chk("R11 async fwd", irq_fwd, 0);
        tick(1);
        rst_n = 1'b1;

        // R4 level held high counts once per acknowledge
        restart(2'b01, 2'b00, 1'b1);
        tick(10);
        chk("R4 held level", pend_cnt, 1);
        chk("R10 fwd", irq_fwd, 1);
        ack = 1'b1; tick(1); ack = 1'b0;
        chk("R4 consumed", pend_cnt, 0);
        tick(1);
        chk("R4 rearmed", pend_cnt, 1);
        tick(5);
        chk("R4 still one", pend_cnt, 1);

        // R9 priority load and hold
        prio_new = 4'hA; prio_load = 1'b1; tick(1); prio_load = 1'b0;
        chk("R9 load", prio, 10);
        prio_new = 4'h3; tick(2);
        chk("R9 hold", prio, 10);

        // R10 grant with nothing pending
        restart(2'b10, 2'b00, 1'b0);
        tick(3);
        chk("R10 idle", irq_fwd, 0);
        chk("R5 idle", ready, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule